// File: doc/BRIEF.md
# Steerable Multi-Mode Interrupt Controller

This block collects up to 32 interrupt sources. Each source is first brought into the clock domain, then judged by a per-source trigger mode: rising edge, falling edge, active-high level, active-low level, or off. A routing bit sends each source to one of two request lines. An enable bit decides whether the source may raise its line. Rising and falling edges are caught in sticky registers whether or not the source is enabled, and software releases them with dedicated clear addresses.

Software reaches every configuration vector through a pair of addresses. Writing ones to the first address sets those bits, and writing ones to the second clears them. Two pending words, one per request line, can be read back. A separate wake-enable vector feeds a single wake output. Reset returns every register to zero, which leaves all sources off.

Top module: `irq_steer_ctrl`

## Requirements
- R1: After reset, every configuration vector, both edge stickies and both pending words read 0, and `irq_out` and `wake_out` are 0.
- R2: Addresses come in pairs. The set address is even and its clear partner is the next odd address: plane A (code bit 0) at 0/1, plane B (code bit 1) at 2/3, plane C (code bit 2) at 4/5, route at 6/7, enable at 8/9, wake at 10/11, spare source-select at 12/13. A write of ones sets or clears exactly those bits, and zero bits keep their value.
- R3: Code {C,B,A}=001 is rising edge. A rising input edge sets a sticky bit that stays pending after the input falls, until a one is written to that bit at address 14.
- R4: Code 010 is falling edge. A falling input edge sets a sticky bit that is cleared by writing a one at address 15. A rising edge does not make a falling-mode source pending.
- R5: Code 101 is active-high level. The pending bit follows the synchronised input and is not latched.
- R6: Code 110 is active-low level. The pending bit is set while the synchronised input is low.
- R7: Codes 000, 011, 100 and 111 never make a source pending.
- R8: A route bit of 1 places the source in pending word 0 (read at address 16). A route bit of 0 places it in pending word 1 (read at address 17).
- R9: An enable bit of 0 keeps the source out of both pending words. Edge capture still runs, so enabling the source later shows an edge caught while it was disabled.
- R10: `irq_out[n]` is the OR of pending word n, registered once. A level source shows in its pending word two clocks after its input changes and on `irq_out` three clocks after.
- R11: `wake_out` is the registered OR of the active sources whose wake bit is 1, independent of the enable bits.
- R12: Reading either address of a pair returns that vector. Address 14 returns the rising sticky, address 15 returns the falling sticky, and any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 32 | Raw asynchronous interrupt inputs |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 32 | Write data, one bit per source |
| rd_addr | input | 5 | Read address |
| rd_data | output | 32 | Combinational read data |
| irq_out | output | 2 | Registered request lines |
| wake_out | output | 1 | Registered wake request |

## Verification
The hardest case to reach from the ports is an edge captured while its source is disabled, which then becomes visible only when the source is enabled. The bench pulses a rising-mode source with its enable bit at 0 and checks that the pending word stays clear. It then sets the enable bit and confirms that the old edge appears. A second delicate case is the three-clock latency from an input change to `irq_out`. A directed test samples the pending word and the request line on the exact clocks where each should first change.

// File: rtl/irq_steer_pkg.sv
`timescale 1ns/1ps
package irq_steer_pkg;
  localparam int ADDR_W = 5;
  localparam int NREG   = 7;   // plane A, B, C, route, enable, wake, spare
  localparam int REG_EN   = 4;
  localparam int REG_WAKE = 5;
  localparam logic [ADDR_W-1:0] A_RISE  = 5'd14;
  localparam logic [ADDR_W-1:0] A_FALL  = 5'd15;
  localparam logic [ADDR_W-1:0] A_PEND0 = 5'd16;
  localparam logic [ADDR_W-1:0] A_PEND1 = 5'd17;

  // Trigger decision for one source: code is {C,B,A}.
  function automatic logic trig_active(input logic [2:0] code, input logic lvl,
                                       input logic rise, input logic fall);
    case (code)
      3'b001:  return rise;
      3'b010:  return fall;
      3'b101:  return lvl;
      3'b110:  return ~lvl;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/irq_setclr_reg.sv
`timescale 1ns/1ps
module irq_setclr_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] bits,
  output logic [W-1:0] q
);
  logic [W-1:0] set_mask, clr_mask;
  assign set_mask = set_en ? bits : '0;
  assign clr_mask = clr_en ? bits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (q | set_mask) & ~clr_mask;
  end

  p_set_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((q & $past(bits)) == $past(bits)));
  p_clr_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> ((q & $past(bits)) == '0));
endmodule

// File: rtl/irq_edge_capture.sv
`timescale 1ns/1ps
module irq_edge_capture #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  input  logic [W-1:0] clr_rise,
  input  logic [W-1:0] clr_fall,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise_q,
  output logic [W-1:0] fall_q
);
  logic [W-1:0] meta_q, sync_q, prev_q;
  logic [W-1:0] rise_evt, fall_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign lvl      = sync_q;
  assign rise_evt = sync_q & ~prev_q;
  assign fall_evt = ~sync_q & prev_q;

  // a new event wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      rise_q <= (rise_q & ~clr_rise) | rise_evt;
      fall_q <= (fall_q & ~clr_fall) | fall_evt;
    end
  end

  p_rise_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt != '0) |=> ((rise_q & $past(rise_evt)) == $past(rise_evt)));
  p_fall_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt != '0) |=> ((fall_q & $past(fall_evt)) == $past(fall_evt)));
endmodule

// File: rtl/irq_trig_eval.sv
`timescale 1ns/1ps
module irq_trig_eval
  import irq_steer_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] plane_a,
  input  logic [W-1:0] plane_b,
  input  logic [W-1:0] plane_c,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] rise,
  input  logic [W-1:0] fall,
  output logic [W-1:0] active
);
  for (genvar i = 0; i < W; i++) begin : g_src
    assign active[i] = trig_active({plane_c[i], plane_b[i], plane_a[i]},
                                   lvl[i], rise[i], fall[i]);
  end
endmodule

// File: rtl/irq_steer_ctrl.sv
`timescale 1ns/1ps
module irq_steer_ctrl
  import irq_steer_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NSRC-1:0]   wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [NSRC-1:0]   rd_data,
  output logic [1:0]        irq_out,
  output logic              wake_out
);
  logic [NSRC-1:0] cfg_q [NREG];
  logic [NSRC-1:0] clr_rise, clr_fall;
  logic [NSRC-1:0] lvl, rise_q, fall_q, active;
  logic [NSRC-1:0] pend0, pend1, wake_vec;
  logic [1:0]      irq_q;
  logic            wake_q;

  for (genvar k = 0; k < NREG; k++) begin : g_cfg
    irq_setclr_reg #(.W(NSRC)) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (wr_en && (wr_addr == ADDR_W'(2*k))),
      .clr_en (wr_en && (wr_addr == ADDR_W'(2*k+1))),
      .bits   (wr_data),
      .q      (cfg_q[k])
    );
  end

  assign clr_rise = (wr_en && wr_addr == A_RISE) ? wr_data : '0;
  assign clr_fall = (wr_en && wr_addr == A_FALL) ? wr_data : '0;

  irq_edge_capture #(.W(NSRC)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw      (src_in),
    .clr_rise (clr_rise),
    .clr_fall (clr_fall),
    .lvl      (lvl),
    .rise_q   (rise_q),
    .fall_q   (fall_q)
  );

  irq_trig_eval #(.W(NSRC)) u_eval (
    .plane_a (cfg_q[0]),
    .plane_b (cfg_q[1]),
    .plane_c (cfg_q[2]),
    .lvl     (lvl),
    .rise    (rise_q),
    .fall    (fall_q),
    .active  (active)
  );

  assign pend0    = active & cfg_q[REG_EN] &  cfg_q[3];
  assign pend1    = active & cfg_q[REG_EN] & ~cfg_q[3];
  assign wake_vec = active & cfg_q[REG_WAKE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q  <= '0;
      wake_q <= 1'b0;
    end else begin
      irq_q  <= {|pend1, |pend0};
      wake_q <= |wake_vec;
    end
  end

  assign irq_out  = irq_q;
  assign wake_out = wake_q;

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NREG; k++) begin
      if (rd_addr == ADDR_W'(2*k) || rd_addr == ADDR_W'(2*k+1)) rd_data = cfg_q[k];
    end
    if (rd_addr == A_RISE)  rd_data = rise_q;
    if (rd_addr == A_FALL)  rd_data = fall_q;
    if (rd_addr == A_PEND0) rd_data = pend0;
    if (rd_addr == A_PEND1) rd_data = pend1;
  end

  p_pend_disjoint_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend0 & pend1) == '0);
  p_req_needs_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q[0] |-> ($past(cfg_q[REG_EN] & cfg_q[3]) != '0));
  p_wake_needs_bit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> ($past(cfg_q[REG_WAKE]) != '0));
endmodule

// File: tb/sim_irq_steer_ctrl.sv
`timescale 1ns/1ps
module sim_irq_steer_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_in = '0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [1:0]  irq_out;
  logic        wake_out;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  irq_steer_ctrl u0 (.clk(clk), .rst_n(rst_n), .src_in(src_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_out(irq_out), .wake_out(wake_out));

  // row: [11:9] code {C,B,A}, [8] route, [7] enable, [6] input before, [5] input after,
  //      [4] expected pending word 0 bit, [3] expected pending word 1 bit
  localparam logic [11:0] VEC [15] = '{
    12'b001_1_1_0_1_1_0_000,  // R3 rising, routed to word 0 (R8)
    12'b001_0_1_0_1_0_1_000,  // R8 route 0 -> word 1
    12'b001_1_1_1_0_0_0_000,  // R3 falling edge ignored
    12'b010_1_1_1_0_1_0_000,  // R4 falling captured
    12'b010_0_1_0_1_0_0_000,  // R4 rising ignored
    12'b101_1_1_0_1_1_0_000,  // R5 high level
    12'b101_0_1_1_0_0_0_000,  // R5 not latched
    12'b110_0_1_1_0_0_1_000,  // R6 low level
    12'b110_1_1_0_1_0_0_000,  // R6 high input quiet
    12'b000_1_1_0_1_0_0_000,  // R7
    12'b011_1_1_0_1_0_0_000,  // R7
    12'b100_1_1_1_0_0_0_000,  // R7
    12'b111_1_1_0_1_0_0_000,  // R7
    12'b101_1_0_0_1_0_0_000,  // R9 level masked
    12'b001_0_0_0_1_0_0_000   // R9 edge masked
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); rd_addr = a; #1 d = rd_data;
  endtask

  task automatic setup(input int k, input logic [2:0] code, input logic route, input logic en);
    if (code[0]) wr(5'd0, 32'd1 << k);
    if (code[1]) wr(5'd2, 32'd1 << k);
    if (code[2]) wr(5'd4, 32'd1 << k);
    if (route)   wr(5'd6, 32'd1 << k);
    if (en)      wr(5'd8, 32'd1 << k);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; src_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic string row_tag(input logic [11:0] r);
    if (!r[7]) return "R9";
    case (r[11:9])
      3'b001: return "R3";
      3'b010: return "R4";
      3'b101: return "R5";
      3'b110: return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    do_reset();
    // R1 reset state
    for (int a = 0; a < 18; a++) begin
      rd(5'(a), v); chk("R1 reset read", v, 32'h0);
    end
    chk("R1 irq_out", {30'd0, irq_out}, 32'h0);
    chk("R1 wake_out", {31'd0, wake_out}, 32'h0);

    // R2 set/clear semantics, R12 read aliases
    wr(5'd8, 32'h0000_00F0); wr(5'd8, 32'h0000_0003);
    rd(5'd8, v); chk("R2 set only ones", v, 32'h0000_00F3);
    wr(5'd9, 32'h0000_0021);
    rd(5'd8, v); chk("R2 clear only ones", v, 32'h0000_00D2);
    rd(5'd9, v); chk("R12 clear alias read", v, 32'h0000_00D2);
    wr(5'd12, 32'h0000_0005);
    rd(5'd13, v); chk("R12 spare read", v, 32'h0000_0005);
    rd(5'd20, v); chk("R12 unused address", v, 32'h0);

    // R3 sticky until cleared
    do_reset();
    setup(20, 3'b001, 1'b1, 1'b1);
    @(negedge clk); src_in[20] = 1'b1;
    repeat (4) @(negedge clk); src_in[20] = 1'b0;
    repeat (4) @(negedge clk);
    rd(5'd14, v); chk("R12 rise sticky read", v, 32'h0010_0000);
    rd(5'd16, v); chk("R3 sticky after input low", v, 32'h0010_0000);
    chk("R3 irq_out0 high", {30'd0, irq_out}, 32'h1);
    wr(5'd14, 32'h0010_0000);
    repeat (2) @(negedge clk);
    rd(5'd16, v); chk("R3 cleared pend", v, 32'h0);
    chk("R3 irq_out0 low", {30'd0, irq_out}, 32'h0);

    // R10 exact latency of a level source on line 1
    do_reset();
    setup(21, 3'b101, 1'b0, 1'b1);
    @(negedge clk); rd_addr = 5'd17; src_in[21] = 1'b1;
    @(negedge clk); #1 chk("R10 pend not yet", rd_data, 32'h0);
    @(negedge clk); #1 chk("R10 pend after 2", rd_data, 32'h0020_0000);
    chk("R10 irq not yet", {30'd0, irq_out}, 32'h0);
    @(negedge clk); #1 chk("R10 irq after 3", {30'd0, irq_out}, 32'h2);

    // R9 capture continues while disabled
    do_reset();
    setup(22, 3'b001, 1'b1, 1'b0);
    @(negedge clk); src_in[22] = 1'b1;
    repeat (4) @(negedge clk); src_in[22] = 1'b0;
    repeat (4) @(negedge clk);
    rd(5'd16, v); chk("R9 masked pend", v, 32'h0);
    chk("R9 masked irq", {30'd0, irq_out}, 32'h0);
    wr(5'd8, 32'h0040_0000);
    rd(5'd16, v); chk("R9 old edge shows", v, 32'h0040_0000);

    // R11 wake independent of enable
    do_reset();
    setup(23, 3'b101, 1'b1, 1'b0);
    wr(5'd10, 32'h0080_0000);
    @(negedge clk); src_in[23] = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 wake high", {31'd0, wake_out}, 32'h1);
    chk("R11 no request", {30'd0, irq_out}, 32'h0);
    src_in[23] = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11 wake low", {31'd0, wake_out}, 32'h0);

    // table walk: one source per row
    do_reset();
    for (int k = 0; k < 15; k++) begin
      logic [11:0] r;
      r = VEC[k];
      setup(k, r[11:9], r[8], r[7]);
      @(negedge clk); src_in[k] = r[6];
      repeat (4) @(negedge clk);
      wr(5'd14, 32'd1 << k); wr(5'd15, 32'd1 << k);
      src_in[k] = r[5];
      repeat (5) @(negedge clk);
      rd(5'd16, v); chk({row_tag(r), " word0"}, {31'd0, v[k]}, {31'd0, r[4]});
      rd(5'd17, v); chk({row_tag(r), " word1"}, {31'd0, v[k]}, {31'd0, r[3]});
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule